// File: doc/BRIEF.md
# Occupancy-Based Adaptive Port Selector

This block picks one output port for an adaptively routed packet in a 64-port router. The router's ports sit in an 8x8 grid of tiles, and port p belongs to column p/8 and row p%8. Each request carries a 64-bit mask of the ports the packet may legally leave on and a 2-bit buffer-occupancy level for every port. The choice is made in two levels. The first level picks a column. Columns that hold a lightly loaded feasible port are preferred over congested ones, and ties go round robin. The second level picks a row inside that column. The least-occupied feasible port wins, and ties again go round robin.

The selection logic is combinational and works from inputs that come from upstream registers. The result is registered, so it appears one cycle after the request. Each level has its own round-robin pointer. A pointer moves only when the downstream consumer accepts the selection currently shown on the outputs.

Top module: `occ_port_selector`

## Requirements
- R1: While rst_ni is low, sel_valid_o is 0 and both round-robin pointers are 0. With all ports feasible and equally loaded, the first request after reset therefore selects port 0.
- R2: Port p has column p/8 and row p%8, and sel_port_o = column*8 + row. A valid selection always names a port whose feasible bit was set in the request.
- R3: A request with an all-zero feasible mask gives sel_valid_o = 0. Asserting accept_i while sel_valid_o is 0 leaves both pointers unchanged.
- R4: A column's occupancy is its lowest 2-bit level. A column counts as congested when that level has its MSB set (level 2 or 3). If any feasible column is uncongested, only uncongested feasible columns can be chosen.
- R5: Among the candidate columns, the first one at or after the column pointer wins, counting upward and wrapping from 7 to 0.
- R6: Within the chosen column, only the feasible ports compete. Among them, those with the lowest 2-bit occupancy level are the candidates. A port that is not feasible has no effect, whatever its occupancy.
- R7: Among the row candidates, the first one at or after the row pointer wins, counting upward and wrapping from 7 to 0.
- R8: When sel_valid_o and accept_i are both 1 at a clock edge, the column pointer becomes (granted column + 1) mod 8 and the row pointer becomes (granted row + 1) mod 8. At every other edge, both pointers keep their values.
- R9: A request presented on req_i at clock edge k appears on sel_valid_o and sel_port_o after edge k. If req_i is 0 at an edge, sel_valid_o is 0 after that edge.
- R10: Only feasible ports count toward a column's occupancy. An infeasible port with level 0 does not make its column uncongested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | A selection request is present this cycle |
| feas_mask_i | input | 64 | Feasible output ports, bit p = port p |
| occ_i | input | 128 | 2-bit occupancy per port, port p at bits [2p+1:2p] |
| accept_i | input | 1 | The consumer takes the selection shown on the outputs |
| sel_valid_o | output | 1 | A selection is valid |
| sel_port_o | output | 6 | Selected port index, column*8 + row |

## Verification
The bench targets the following cases, each paired with the fault it would expose:
- **Infeasible low-occupancy port beside a congested feasible one.** A design that takes the column minimum over all ports would pick the wrong column.
- **Uncongested column placed after congested columns in round-robin order.** A design that ignores the MSB preference would grant the congested column first.
- **Row ties on either side of the row pointer.** A stale or non-advancing pointer would grant the same row twice.
- **Empty masks together with a stray accept.** A design that moves its pointers without a valid selection would shift every later grant.

A long pseudo-random sweep over masks, occupancies and accept patterns then compares every result with an arithmetic model of the requirements.

// File: rtl/occ_sel_pkg.sv
package occ_sel_pkg;
  localparam int unsigned DEF_COLS  = 8;
  localparam int unsigned DEF_ROWS  = 8;
  localparam int unsigned DEF_OCC_W = 2;
endpackage

// File: rtl/occ_sel_rr_pick.sv
module occ_sel_rr_pick #(
  parameter int unsigned N  = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  cand_i,
  input  logic [IW-1:0] ptr_i,
  output logic          any_o,
  output logic [IW-1:0] grant_o
);
  always_comb begin
    int unsigned idx;
    any_o   = 1'b0;
    grant_o = '0;
    for (int unsigned k = 0; k < N; k++) begin
      idx = (int'(ptr_i) + k) % N;
      if (!any_o && cand_i[idx]) begin
        any_o   = 1'b1;
        grant_o = IW'(idx);
      end
    end
  end

  always_comb begin
    if (any_o) assert_grant_in_cand_R5: assert (cand_i[grant_o]);
  end
endmodule

// File: rtl/occ_sel_col_stage.sv
module occ_sel_col_stage #(
  parameter int unsigned NUM_COLS = occ_sel_pkg::DEF_COLS,
  parameter int unsigned NUM_ROWS = occ_sel_pkg::DEF_ROWS,
  parameter int unsigned OCC_W    = occ_sel_pkg::DEF_OCC_W,
  localparam int unsigned NP = NUM_COLS * NUM_ROWS,
  localparam int unsigned CW = $clog2(NUM_COLS)
) (
  input  logic [NP-1:0]       feas_i,
  input  logic [NP*OCC_W-1:0] occ_i,
  input  logic [CW-1:0]       ptr_i,
  output logic                any_o,
  output logic [CW-1:0]       col_o
);
  logic [NUM_COLS-1:0] col_feas, col_busy, col_free, col_cand;

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    logic [OCC_W-1:0] col_min;
    assign col_feas[c] = |feas_i[c*NUM_ROWS +: NUM_ROWS];
    // minimum over feasible ports only
    always_comb begin
      col_min = '1;
      for (int unsigned r = 0; r < NUM_ROWS; r++) begin
        if (feas_i[c*NUM_ROWS+r] &&
            occ_i[(c*NUM_ROWS+r)*OCC_W +: OCC_W] < col_min)
          col_min = occ_i[(c*NUM_ROWS+r)*OCC_W +: OCC_W];
      end
    end
    assign col_busy[c] = col_min[OCC_W-1];
  end

  assign col_free = col_feas & ~col_busy;
  assign col_cand = (|col_free) ? col_free : col_feas;

  occ_sel_rr_pick #(.N(NUM_COLS)) u_rr (
    .cand_i (col_cand),
    .ptr_i  (ptr_i),
    .any_o  (any_o),
    .grant_o(col_o)
  );

  always_comb begin
    if (any_o) begin
      assert_col_feasible_R2: assert (col_feas[col_o]);
      if (|col_free) assert_col_uncongested_R4: assert (!col_busy[col_o]);
    end
  end
endmodule

// File: rtl/occ_sel_row_stage.sv
module occ_sel_row_stage #(
  parameter int unsigned NUM_COLS = occ_sel_pkg::DEF_COLS,
  parameter int unsigned NUM_ROWS = occ_sel_pkg::DEF_ROWS,
  parameter int unsigned OCC_W    = occ_sel_pkg::DEF_OCC_W,
  localparam int unsigned NP = NUM_COLS * NUM_ROWS,
  localparam int unsigned CW = $clog2(NUM_COLS),
  localparam int unsigned RW = $clog2(NUM_ROWS)
) (
  input  logic [NP-1:0]       feas_i,
  input  logic [NP*OCC_W-1:0] occ_i,
  input  logic [CW-1:0]       col_i,
  input  logic [RW-1:0]       ptr_i,
  output logic                any_o,
  output logic [RW-1:0]       row_o
);
  logic [NUM_ROWS-1:0]  row_feas, row_cand;
  logic [OCC_W-1:0]     row_occ [NUM_ROWS];
  logic [OCC_W-1:0]     row_min;

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    assign row_feas[r] = feas_i[int'(col_i)*NUM_ROWS + r];
    assign row_occ[r]  = occ_i[(int'(col_i)*NUM_ROWS + r)*OCC_W +: OCC_W];
    assign row_cand[r] = row_feas[r] && (row_occ[r] == row_min);
  end

  always_comb begin
    row_min = '1;
    for (int unsigned r = 0; r < NUM_ROWS; r++)
      if (row_feas[r] && row_occ[r] < row_min) row_min = row_occ[r];
  end

  occ_sel_rr_pick #(.N(NUM_ROWS)) u_rr (
    .cand_i (row_cand),
    .ptr_i  (ptr_i),
    .any_o  (any_o),
    .grant_o(row_o)
  );

  always_comb begin
    if (any_o) begin
      assert_row_feasible_R6: assert (row_feas[row_o]);
      for (int unsigned r = 0; r < NUM_ROWS; r++)
        if (row_feas[r]) assert_row_least_R6: assert (row_occ[r] >= row_occ[row_o]);
    end
  end
endmodule

// File: rtl/occ_port_selector.sv
module occ_port_selector #(
  parameter int unsigned NUM_COLS = occ_sel_pkg::DEF_COLS,
  parameter int unsigned NUM_ROWS = occ_sel_pkg::DEF_ROWS,
  parameter int unsigned OCC_W    = occ_sel_pkg::DEF_OCC_W,
  localparam int unsigned NP = NUM_COLS * NUM_ROWS,
  localparam int unsigned CW = $clog2(NUM_COLS),
  localparam int unsigned RW = $clog2(NUM_ROWS),
  localparam int unsigned PW = CW + RW
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [NP-1:0]       feas_mask_i,
  input  logic [NP*OCC_W-1:0] occ_i,
  input  logic                accept_i,
  output logic                sel_valid_o,
  output logic [PW-1:0]       sel_port_o
);
  logic [CW-1:0] col_ptr_q, col_sel;
  logic [RW-1:0] row_ptr_q, row_sel;
  logic          col_any, row_any, take;

  occ_sel_col_stage #(.NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS), .OCC_W(OCC_W)) u_col (
    .feas_i(feas_mask_i),
    .occ_i (occ_i),
    .ptr_i (col_ptr_q),
    .any_o (col_any),
    .col_o (col_sel)
  );

  occ_sel_row_stage #(.NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS), .OCC_W(OCC_W)) u_row (
    .feas_i(feas_mask_i),
    .occ_i (occ_i),
    .col_i (col_sel),
    .ptr_i (row_ptr_q),
    .any_o (row_any),
    .row_o (row_sel)
  );

  assign take = sel_valid_o && accept_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_valid_o <= 1'b0;
      sel_port_o  <= '0;
      col_ptr_q   <= '0;
      row_ptr_q   <= '0;
    end else begin
      sel_valid_o <= req_i && col_any && row_any;
      sel_port_o  <= {col_sel, row_sel};
      if (take) begin
        col_ptr_q <= sel_port_o[PW-1 -: CW] + 1'b1;
        row_ptr_q <= sel_port_o[RW-1:0] + 1'b1;
      end
    end
  end

  assert_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> sel_valid_o == $past(req_i && (|feas_mask_i)));

  assert_sel_feasible_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o |-> ((($past(feas_mask_i) >> sel_port_o) & NP'(1)) != '0));

  assert_ptr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take |=> $stable(col_ptr_q) && $stable(row_ptr_q));

  assert_ptr_adv_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> col_ptr_q == CW'($past(sel_port_o[PW-1 -: CW]) + 1'b1) &&
             row_ptr_q == RW'($past(sel_port_o[RW-1:0]) + 1'b1));
endmodule

// File: tb/occ_port_selector_tb_top.sv
module occ_port_selector_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_i = 1'b0;
  logic [63:0]  feas_mask_i = '0;
  logic [127:0] occ_i = '0;
  logic         accept_i = 1'b0;
  logic         sel_valid_o;
  logic [5:0]   sel_port_o;

  int n_tests = 0, n_fail = 0;
  int cp = 0, rp = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  occ_port_selector dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .feas_mask_i(feas_mask_i),
    .occ_i(occ_i), .accept_i(accept_i), .sel_valid_o(sel_valid_o), .sel_port_o(sel_port_o)
  );

  // arithmetic model of R2..R7, returns -1 for no selection
  function automatic int model(input logic [63:0] m, input logic [127:0] o, input int c_p, input int r_p);
    int cmin[8];
    bit cf[8];
    bit anyfree;
    int col, row, rmin;
    if (m == '0) return -1;
    anyfree = 0;
    for (int c = 0; c < 8; c++) begin
      cf[c] = 0; cmin[c] = 4;
      for (int r = 0; r < 8; r++)
        if (m[c*8+r]) begin
          cf[c] = 1;
          if (int'(o[(c*8+r)*2 +: 2]) < cmin[c]) cmin[c] = int'(o[(c*8+r)*2 +: 2]);
        end
      if (cf[c] && cmin[c] < 2) anyfree = 1;
    end
    col = -1;
    for (int k = 0; k < 8; k++) begin
      int c = (c_p + k) % 8;
      if (col < 0 && cf[c] && (!anyfree || cmin[c] < 2)) col = c;
    end
    rmin = 4;
    for (int r = 0; r < 8; r++)
      if (m[col*8+r] && int'(o[(col*8+r)*2 +: 2]) < rmin) rmin = int'(o[(col*8+r)*2 +: 2]);
    row = -1;
    for (int k = 0; k < 8; k++) begin
      int r = (r_p + k) % 8;
      if (row < 0 && m[col*8+r] && int'(o[(col*8+r)*2 +: 2]) == rmin) row = r;
    end
    return col*8 + row;
  endfunction

  task automatic check(input int got, input int want, input string tag);
    n_tests++;
    if (got != want) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, want);
    end
  endtask

  // one request, sampled one cycle later (R9), optional accept afterwards
  task automatic run(input logic [63:0] m, input logic [127:0] o, input bit acc,
                     input bit use_exp, input int exp_port, input string tag);
    int want, got;
    @(negedge clk_i);
    req_i = 1'b1; feas_mask_i = m; occ_i = o; accept_i = 1'b0;
    @(negedge clk_i);
    req_i = 1'b0;
    want = use_exp ? exp_port : model(m, o, cp, rp);
    got  = sel_valid_o ? int'(sel_port_o) : -1;
    check(got, want, tag);
    accept_i = acc;
    @(negedge clk_i);
    accept_i = 1'b0;
    check(int'(sel_valid_o), 0, "R9 valid drops without req");
    if (acc && want >= 0) begin
      cp = (want / 8 + 1) % 8;
      rp = (want % 8 + 1) % 8;
    end
  endtask

  function automatic logic [127:0] put(input logic [127:0] o, input int p, input int v);
    logic [127:0] t = o;
    t[p*2 +: 2] = 2'(v);
    return t;
  endfunction

  initial begin
    logic [63:0]  m;
    logic [127:0] o;
    repeat (3) @(negedge clk_i);
    check(int'(sel_valid_o), 0, "R1 valid low in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(int'(sel_valid_o), 0, "R1 valid low after reset");

    run('1, '0, 1, 1, 0,  "R1 first grant is port 0");
    run('1, '0, 0, 1, 9,  "R8 pointers advanced to 1,1");
    run('1, '0, 1, 1, 9,  "R8 no advance without accept");
    run('0, '0, 1, 1, -1, "R3 empty mask gives no valid");
    run('1, '0, 0, 1, 18, "R3 stray accept leaves pointers");

    // R4: col2 fully feasible at level 3, col5 row0 at level 1
    m = 64'hFF << 16; o = '0;
    for (int r = 0; r < 8; r++) o = put(o, 16+r, 3);
    m[40] = 1'b1; o = put(o, 40, 1);
    run(m, o, 0, 1, 40, "R4 uncongested column preferred");

    // R10: col3 infeasible row5 at 0 must not unload col3
    m = '0; o = '0;
    m[28] = 1'b1; o = put(o, 28, 2);
    o = put(o, 29, 0);
    m[57] = 1'b1; o = put(o, 57, 1);
    run(m, o, 0, 1, 57, "R10 infeasible port ignored in column load");

    // R6: col4, levels row0=3 row1=2 row2=1 row3=2 row6=1, row4 infeasible at 0
    m = '0; o = '1;
    m[32] = 1; o = put(o, 32, 3);
    m[33] = 1; o = put(o, 33, 2);
    m[34] = 1; o = put(o, 34, 1);
    m[35] = 1; o = put(o, 35, 2);
    m[38] = 1; o = put(o, 38, 1);
    o = put(o, 36, 0);
    run(m, o, 1, 1, 34, "R6 least occupied row");
    run(m, o, 0, 1, 38, "R7 row tie after pointer");

    // R5: all columns row0 only, column pointer 5, row pointer wraps
    m = '0; o = '0;
    for (int c = 0; c < 8; c++) m[c*8] = 1'b1;
    run(m, o, 1, 1, 40, "R5 column tie from pointer");
    run(m, o, 1, 1, 48, "R5 column pointer advanced");
    run(m, o, 1, 1, 56, "R5 column 7");
    run(m, o, 1, 1, 0,  "R5 column wraps to 0");

    for (int i = 0; i < 800; i++) begin
      m = {$urandom, $urandom};
      if (i % 3 == 1) m = m & {$urandom, $urandom} & {$urandom, $urandom};
      if (i % 3 == 2) m = (64'd1 << ($urandom % 64)) | (64'd1 << ($urandom % 64));
      if (i % 19 == 0) m = '0;
      o = {$urandom, $urandom, $urandom, $urandom};
      run(m, o, 1'($urandom % 2), 0, 0, "R2 R4 R5 R6 R7 R8 random sweep");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule